// File: doc/BRIEF.md
# Four-Channel Shadow-Reload Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from a small 32-bit register bus. Each channel holds a period length and a duty count in software-visible configuration registers. A channel does not run directly from those registers. When its start bit rises, the configuration is copied into private working registers, and the waveform runs from that copy. Software can then rewrite the configuration at any time without disturbing the running waveform.

To retarget a running channel, software writes the new duty and period values, then writes its update bit to 1 and back to 0. The falling edge commits the request. The working copy is reloaded at the next period boundary, so no period is cut short. A per-channel polarity bit selects which output level the duty count measures. A per-channel drive-enable bit switches the pin between driving and released. A read-only status register reports which channels have completed a full period since they were last started. The counters run on the bus clock with no prescaler.

Top module: `pwm_shadow_top`

## Requirements
- R1: After reset, every duty register reads 1, every period register reads 2, polarity, start and update read 0, drive-enable reads 0xF, status reads 0, pwmOut is 0 and pwmOe is 0xF.
- R2: Register byte addresses are as follows. Duty count of channel n is at 8n and its period is at 8n+4. Polarity is at 0x40, start at 0x44, status at 0x48, update at 0x4C and drive-enable at 0xD0, with bit n of each belonging to channel n. The status register ignores writes, and unmapped addresses read 0.
- R3: A 0-to-1 change of start bit n copies channel n's duty and period into its working copy and restarts its counter. The clock edge that takes the write begins the first period.
- R4: Each period lasts the working period in cycles. Its first duty-count cycles are at the counted level, which is low when the polarity bit is 0 and high when it is 1. The remaining cycles are at the opposite level.
- R5: A duty count of 0 gives a constant output at the uncounted level, which is constant high at polarity 0. A duty count at or above the period gives the counted level throughout.
- R6: Period and duty registers hold 30 bits, and higher written bits are dropped. A period below 2 is run as 2.
- R7: While a channel runs, writes to its duty or period registers do not change its output. Writing only a 1 to its update bit also has no effect.
- R8: Writing update bit n to 1 and then to 0 while channel n runs reloads its working copy at the next period boundary.
- R9: A channel whose start bit is 0 drives pwmOut low.
- R10: A drive-enable bit of 0 releases the pin: pwmOe[n] is 0 and pwmOut[n] is held 0.
- R11: Status bit n sets when channel n completes its first period after a start, and clears on the next 0-to-1 change of its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | 8 | Byte address of the accessed word |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | 4 | Waveform output per channel |
| pwmOe | output | 4 | Pin drive enable per channel |

## Verification
The assertions check five rules on every cycle. A stopped or released channel keeps its output low. A running working period is never below 2. The working copy of a running channel stays put between period boundaries. The status bit is clear right after a start. The bench's scenarios are needed for the rest. They count high cycles over one period for both polarities, for a zero duty, for a duty past the period and for a clamped period. They show that the update bit takes effect only after its 1-then-0 sequence, and they cover readback of the register map, dropped upper bits and the ignored status write.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int CH_COUNT = 4;
  localparam int CNT_W    = 30;
  localparam int ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] ADDR_POL   = 8'h40;
  localparam logic [ADDR_W-1:0] ADDR_START = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_UPD   = 8'h4C;
  localparam logic [ADDR_W-1:0] ADDR_OE    = 8'hD0;
  localparam int CH_STRIDE = 8;

  // control-to-datapath strobes
  typedef struct packed {
    logic [CH_COUNT-1:0] startLoad;  // copy config into working copy, restart counter
    logic [CH_COUNT-1:0] reloadNow;  // reload working copy at this wrap
    logic [CH_COUNT-1:0] runEn;      // channel running
  } chanStrobe_t;
endpackage

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busWr,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [31:0]                        busWData,
  output logic [31:0]                        busRData,
  input  logic [CH_COUNT-1:0]                wrapVec,
  output logic [CH_COUNT-1:0][CNT_W_P-1:0]   cfgDuty,
  output logic [CH_COUNT-1:0][CNT_W_P-1:0]   cfgPer,
  output logic [CH_COUNT-1:0]                polMask,
  output logic [CH_COUNT-1:0]                oeMask,
  output logic [CH_COUNT-1:0]                doneMask,
  output chanStrobe_t                        stb
);
  logic [CH_COUNT-1:0] startReg, updReg, pendReg, freshReg;
  logic [CH_COUNT-1:0] startRise, updFall;
  logic wrPol, wrStart, wrUpd, wrOe;
  logic unusedWData;

  assign unusedWData = ^busWData[31:CNT_W_P];

  assign wrPol   = busWr && (busAddr == ADDR_POL);
  assign wrStart = busWr && (busAddr == ADDR_START);
  assign wrUpd   = busWr && (busAddr == ADDR_UPD);
  assign wrOe    = busWr && (busAddr == ADDR_OE);

  assign startRise = wrStart ? (busWData[CH_COUNT-1:0] & ~startReg) : '0;
  assign updFall   = wrUpd   ? (updReg & ~busWData[CH_COUNT-1:0])   : '0;

  assign stb.startLoad = startRise;
  assign stb.runEn     = startReg;
  assign stb.reloadNow = pendReg & wrapVec;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < CH_COUNT; n++) begin
        cfgDuty[n] <= CNT_W_P'(1);
        cfgPer[n]  <= CNT_W_P'(2);
      end
      polMask  <= '0;
      startReg <= '0;
      updReg   <= '0;
      oeMask   <= '1;
    end else if (busWr) begin
      for (int n = 0; n < CH_COUNT; n++) begin
        if (busAddr == ADDR_W'(CH_STRIDE*n))     cfgDuty[n] <= busWData[CNT_W_P-1:0];
        if (busAddr == ADDR_W'(CH_STRIDE*n + 4)) cfgPer[n]  <= busWData[CNT_W_P-1:0];
      end
      if (wrPol)   polMask  <= busWData[CH_COUNT-1:0];
      if (wrStart) startReg <= busWData[CH_COUNT-1:0];
      if (wrUpd)   updReg   <= busWData[CH_COUNT-1:0];
      if (wrOe)    oeMask   <= busWData[CH_COUNT-1:0];
    end
  end

  // reload request and completion tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg  <= '0;
      freshReg <= '0;
      doneMask <= '0;
    end else begin
      for (int n = 0; n < CH_COUNT; n++) begin
        if (startRise[n])                   pendReg[n] <= 1'b0;
        else if (updFall[n] && startReg[n]) pendReg[n] <= 1'b1;
        else if (stb.reloadNow[n])          pendReg[n] <= 1'b0;

        if (startRise[n]) begin
          freshReg[n] <= 1'b1;
          doneMask[n] <= 1'b0;
        end else if (wrapVec[n]) begin
          if (freshReg[n]) doneMask[n] <= 1'b1;
          freshReg[n] <= stb.reloadNow[n];
        end
      end
    end
  end

  // read mux
  always_comb begin
    busRData = '0;
    for (int n = 0; n < CH_COUNT; n++) begin
      if (busAddr == ADDR_W'(CH_STRIDE*n))     busRData[CNT_W_P-1:0] = cfgDuty[n];
      if (busAddr == ADDR_W'(CH_STRIDE*n + 4)) busRData[CNT_W_P-1:0] = cfgPer[n];
    end
    case (busAddr)
      ADDR_POL:   busRData[CH_COUNT-1:0] = polMask;
      ADDR_START: busRData[CH_COUNT-1:0] = startReg;
      ADDR_STAT:  busRData[CH_COUNT-1:0] = doneMask;
      ADDR_UPD:   busRData[CH_COUNT-1:0] = updReg;
      ADDR_OE:    busRData[CH_COUNT-1:0] = oeMask;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwm_shadow_dp.sv
module pwm_shadow_dp
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  chanStrobe_t                      stb,
  input  logic [CH_COUNT-1:0][CNT_W_P-1:0] cfgDuty,
  input  logic [CH_COUNT-1:0][CNT_W_P-1:0] cfgPer,
  input  logic [CH_COUNT-1:0]              polMask,
  input  logic [CH_COUNT-1:0]              oeMask,
  output logic [CH_COUNT-1:0]              wrapVec,
  output logic [CH_COUNT-1:0][CNT_W_P-1:0] workPer,
  output logic [CH_COUNT-1:0][CNT_W_P-1:0] workDuty,
  output logic [CH_COUNT-1:0]              pwmOut,
  output logic [CH_COUNT-1:0]              pwmOe
);
  localparam logic [CNT_W_P-1:0] MIN_PER = CNT_W_P'(2);

  assign pwmOe = oeMask;

  for (genvar n = 0; n < CH_COUNT; n++) begin : g_chan
    logic [CNT_W_P-1:0] cnt;
    logic [CNT_W_P-1:0] loadPer;
    logic               level;

    assign loadPer    = (cfgPer[n] < MIN_PER) ? MIN_PER : cfgPer[n];
    assign wrapVec[n] = stb.runEn[n] && (cnt == workPer[n] - CNT_W_P'(1));
    assign level      = (cnt < workDuty[n]) ? polMask[n] : ~polMask[n];
    assign pwmOut[n]  = stb.runEn[n] & oeMask[n] & level;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt         <= '0;
        workPer[n]  <= MIN_PER;
        workDuty[n] <= CNT_W_P'(1);
      end else if (stb.startLoad[n]) begin
        cnt         <= '0;
        workPer[n]  <= loadPer;
        workDuty[n] <= cfgDuty[n];
      end else if (stb.runEn[n]) begin
        if (wrapVec[n]) begin
          cnt <= '0;
          if (stb.reloadNow[n]) begin
            workPer[n]  <= loadPer;
            workDuty[n] <= cfgDuty[n];
          end
        end else begin
          cnt <= cnt + CNT_W_P'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_shadow_top.sv
module pwm_shadow_top
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWData,
  output logic [31:0]         busRData,
  output logic [CH_COUNT-1:0] pwmOut,
  output logic [CH_COUNT-1:0] pwmOe
);
  chanStrobe_t                      ctrlStb;
  logic [CH_COUNT-1:0]              wrapVec, polMask, oeMask, doneMask;
  logic [CH_COUNT-1:0][CNT_W_P-1:0] cfgDuty, cfgPer, workPer, workDuty;

  pwm_shadow_ctrl #(.CNT_W_P(CNT_W_P)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .wrapVec(wrapVec),
    .cfgDuty(cfgDuty), .cfgPer(cfgPer), .polMask(polMask),
    .oeMask(oeMask), .doneMask(doneMask), .stb(ctrlStb)
  );

  pwm_shadow_dp #(.CNT_W_P(CNT_W_P)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .cfgDuty(cfgDuty),
    .cfgPer(cfgPer), .polMask(polMask), .oeMask(oeMask),
    .wrapVec(wrapVec), .workPer(workPer), .workDuty(workDuty),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );
endmodule

// File: rtl/pwm_shadow_checker.sv
module pwm_shadow_checker
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [CH_COUNT-1:0]              runMask,
  input logic [CH_COUNT-1:0]              startLoad,
  input logic [CH_COUNT-1:0]              wrapVec,
  input logic [CH_COUNT-1:0]              doneMask,
  input logic [CH_COUNT-1:0]              pwmOut,
  input logic [CH_COUNT-1:0]              pwmOe,
  input logic [CH_COUNT-1:0][CNT_W_P-1:0] workPer,
  input logic [CH_COUNT-1:0][CNT_W_P-1:0] workDuty
);
  for (genvar n = 0; n < CH_COUNT; n++) begin : g_chk
    assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rstN)
      !runMask[n] |-> !pwmOut[n]);

    assert_released_low_R10: assert property (@(posedge clk) disable iff (!rstN)
      !pwmOe[n] |-> !pwmOut[n]);

    assert_min_period_R6: assert property (@(posedge clk) disable iff (!rstN)
      workPer[n] >= CNT_W_P'(2));

    // R7 and R8: the working copy moves only at a start or a period boundary
    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      (runMask[n] && !wrapVec[n] && !startLoad[n]) |=>
        ($stable(workDuty[n]) && $stable(workPer[n])));

    assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
      startLoad[n] |=> !doneMask[n]);
  end
endmodule

bind pwm_shadow_top pwm_shadow_checker #(.CNT_W_P(CNT_W_P)) u_chk (
  .clk(clk), .rstN(rstN), .runMask(ctrlStb.runEn), .startLoad(ctrlStb.startLoad),
  .wrapVec(wrapVec), .doneMask(doneMask), .pwmOut(pwmOut), .pwmOe(pwmOe),
  .workPer(workPer), .workDuty(workDuty)
);

// File: tb/pwm_shadow_top_bench.sv
module pwm_shadow_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic [3:0]  pwmOut, pwmOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_shadow_top u_pwm_shadow_top (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWData(busWData), .busRData(busRData), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  typedef struct packed {
    logic        pol;
    logic [15:0] duty;
    logic [15:0] per;
    logic [15:0] win;
    logic [15:0] expHigh;
  } vec_t;

  // polarity, duty, period, window (effective period), expected high cycles
  localparam vec_t VEC [10] = '{
    '{1'b0, 16'd1, 16'd2,  16'd2,  16'd1},   // R4 fastest rate
    '{1'b0, 16'd3, 16'd10, 16'd10, 16'd7},   // R4 low-count
    '{1'b1, 16'd3, 16'd10, 16'd10, 16'd3},   // R4 high-count
    '{1'b0, 16'd0, 16'd5,  16'd5,  16'd5},   // R5 zero duty, constant high
    '{1'b1, 16'd0, 16'd5,  16'd5,  16'd0},   // R5 zero duty, inverted
    '{1'b0, 16'd8, 16'd4,  16'd4,  16'd0},   // R5 duty past period
    '{1'b1, 16'd8, 16'd4,  16'd4,  16'd4},   // R5 duty past period, inverted
    '{1'b0, 16'd1, 16'd0,  16'd2,  16'd1},   // R6 period 0 clamps to 2
    '{1'b0, 16'd1, 16'd1,  16'd2,  16'd1},   // R6 period 1 clamps to 2
    '{1'b1, 16'd2, 16'd7,  16'd7,  16'd2}    // R4 odd period
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRData;
  endtask

  // counts high samples of channel ch over win cycles, starting at the current negedge
  task automatic countHigh(input int ch, input int win, output int highs);
    highs = 0;
    for (int i = 0; i < win; i++) begin
      if (pwmOut[ch]) highs++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 pwmOut", {28'd0, pwmOut}, 32'h0);
    check("R1 pwmOe", {28'd0, pwmOe}, 32'hF);
    rd(8'h00, d); check("R1 duty0", d, 32'd1);
    rd(8'h1C, d); check("R1 period3", d, 32'd2);
    rd(8'hD0, d); check("R1 drive-enable", d, 32'hF);
    rd(8'h44, d); check("R1 start", d, 32'h0);
    rd(8'h48, d); check("R1 status", d, 32'h0);

    // R2 register map and write-ignored status
    wr(8'h48, 32'hF); rd(8'h48, d); check("R2 status ignores writes", d, 32'h0);
    wr(8'h40, 32'h5); rd(8'h40, d); check("R2 polarity readback", d, 32'h5);
    wr(8'h40, 32'h0);
    wr(8'h14, 32'd77); rd(8'h14, d); check("R2 period2 at 0x14", d, 32'd77);
    rd(8'h80, d); check("R2 unmapped reads 0", d, 32'h0);
    // R6 upper bits dropped
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); check("R6 period width", d, 32'h3FFF_FFFF);

    // table: R3 R4 R5 R6 on rotating channels
    for (int i = 0; i < 10; i++) begin
      int ch;
      ch = i % 4;
      wr(8'h44, 32'h0);
      wr(8'(8*ch), {16'd0, VEC[i].duty});
      wr(8'(8*ch + 4), {16'd0, VEC[i].per});
      wr(8'h40, VEC[i].pol ? (32'd1 << ch) : 32'd0);
      wr(8'h44, 32'd1 << ch);
      countHigh(ch, int'(VEC[i].win), h);
      check($sformatf("R4 vector %0d high cycles", i), h, {16'd0, VEC[i].expHigh});
    end
    wr(8'h44, 32'h0);
    wr(8'h40, 32'h0);

    // R7 / R8 / R11 on channel 1
    wr(8'h08, 32'd2);
    wr(8'h0C, 32'd4);
    wr(8'h44, 32'h2);
    rd(8'h48, d); check("R11 status clear after start", d & 32'h2, 32'h0);
    countHigh(1, 4, h); check("R3 start runs copy", h, 32'd2);
    wr(8'h08, 32'd0);
    repeat (5) @(negedge clk);
    countHigh(1, 4, h); check("R7 running write ignored", h, 32'd2);
    wr(8'h4C, 32'h2);
    repeat (5) @(negedge clk);
    countHigh(1, 4, h); check("R7 update high alone ignored", h, 32'd2);
    wr(8'h4C, 32'h0);
    repeat (6) @(negedge clk);
    countHigh(1, 4, h); check("R8 reload after update pulse", h, 32'd4);
    rd(8'h48, d); check("R11 status set after period", d & 32'h2, 32'h2);

    // R9 stopped channel low
    wr(8'h44, 32'h0);
    countHigh(1, 6, h); check("R9 stopped output low", h, 32'd0);
    wr(8'h44, 32'h2);
    rd(8'h48, d); check("R11 status clears on restart", d & 32'h2, 32'h0);
    wr(8'h44, 32'h0);

    // R10 drive enable on channel 2
    wr(8'h10, 32'd100);
    wr(8'h14, 32'd200);
    wr(8'h40, 32'h4);
    wr(8'h44, 32'h4);
    #1 check("R4 channel2 high before release", {31'd0, pwmOut[2]}, 32'd1);
    wr(8'hD0, 32'hB);
    #1 check("R10 pwmOe released", {28'd0, pwmOe}, 32'hB);
    check("R10 released output low", {31'd0, pwmOut[2]}, 32'd0);
    wr(8'hD0, 32'hF);
    #1 check("R10 output returns", {31'd0, pwmOut[2]}, 32'd1);
    wr(8'h44, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule